// File: doc/BRIEF.md
# Four-Level Page Table Walker

This block turns a 48-bit virtual address into a physical address. It walks a four-level page table held in memory, starting at a root table base. At each level it reads one 64-bit entry through a request/acknowledge memory port. The walk ends early at the second level when that entry maps a large page.

When the last entry has been read, the block checks the access type (read, write, instruction fetch, user or supervisor) against the permission bits of every entry on the path. If the access is allowed, it writes back the accessed and dirty bits. It then reports the physical address, a fault flag and a 5-bit error code for one cycle.

Only one walk runs at a time. A new request is taken only while the block is idle.

Top module: `pt_walker`

## Requirements
- R1: The entry for level L (4 first, then 3, 2, 1) is read at table base + 8 × ((va >> (12 + 9·(L−1))) & 511). Levels are read in descending order, and entry addresses are always 8-byte aligned.
- R2: The table base for the next level is bits 39..12 of the present entry, with bits 11..0 zero. The level-4 base is `root_base` with its low 12 bits cleared.
- R3: If bit 7 of the level-2 entry is set, the walk ends after that read and level 1 is never read. The physical address is {entry[39:22], 0, va[20:0]}, so base bit 21 is treated as cleared.
- R4: On a 4 KiB mapping without a fault, `pa` = {level-1 entry[39:12], va[11:0]}.
- R5: An entry with bit 0 clear ends the walk with a fault, and no deeper level is read. Error bit 0 is then 0; for every other fault it is 1.
- R6: An entry with bit 51 set, or with bit 63 set while `nx_en` is 0, is a reserved-bit fault. It ends the walk, no deeper level is read, and error bits 3 and 0 are set.
- R7: After the walk, the access faults if any of these holds for an entry read:
  - a user access meets an entry with bit 2 clear;
  - a write meets an entry with bit 1 clear while `wp_en` or user is set;
  - a fetch meets an entry with bit 63 set while `nx_en` is 1.

  Error bit 1 mirrors write, bit 2 mirrors user, and bit 4 mirrors fetch only while `nx_en` is 1.
- R8: On a fault-free walk, bit 5 (accessed) is set in every entry read, and bit 6 (dirty) is set in the final entry on writes. Only entries whose value changes are written back, highest level first. A faulting walk writes nothing, and `pa` reads 0.
- R9: `mem_req` and its address stay steady until `mem_ack`. `done` is a one-cycle pulse. A request raised while `busy` is high is ignored.
- R10: After reset, `busy`, `done` and `mem_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Start a walk (taken when idle) |
| req_va | input | 48 | Virtual address |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access is from user level |
| req_fetch | input | 1 | Access is an instruction fetch |
| wp_en | input | 1 | Supervisor writes honour read-only entries |
| nx_en | input | 1 | No-execute bit enabled |
| root_base | input | 40 | Level-4 table base |
| busy | output | 1 | Walk in progress |
| done | output | 1 | Result valid pulse |
| fault | output | 1 | Access faulted |
| err_code | output | 5 | Fault error code |
| pa | output | 40 | Translated physical address |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 40 | Memory byte address |
| mem_wdata | output | 64 | Write data |
| mem_ack | input | 1 | Memory acknowledge |
| mem_rdata | input | 64 | Read data, valid with ack |

## Verification
The bench targets these corner cases:
- **Not-present and reserved entries at mid levels.** A walker that kept reading would show extra memory reads. A walker that mixed up the two fault kinds would report the wrong error bit 0 or 3.
- **A no-execute bit with `nx_en` off.** This must be a reserved fault with the fetch bit cleared. A design that treated it as a permission fault would leave error bit 3 clear.
- **Large pages with base bit 21 set.** A walker that read level 1 anyway, or kept bit 21, would show an extra read or a wrong address.
- **Write-back filtering.** Walks whose upper entries are already accessed must write only the leaf. Faulting walks must write nothing. A design that wrote early would corrupt entries on faults.
- **A read-only page under both `wp_en` settings.** A design that ignored the supervisor override would fault, or fail to fault, on the wrong setting.

// File: rtl/pt_walker.sv
module pt_walker #(
  parameter int VA_W    = 48,
  parameter int PA_W    = 40,
  parameter int E_W     = 64,
  parameter int IDX_W   = 9,
  parameter int OFF_W   = 12,
  parameter int RSV_BIT = 51,
  parameter int NX_BIT  = 63
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic [VA_W-1:0] req_va,
  input  logic            req_write,
  input  logic            req_user,
  input  logic            req_fetch,
  input  logic            wp_en,
  input  logic            nx_en,
  input  logic [PA_W-1:0] root_base,
  output logic            busy,
  output logic            done,
  output logic            fault,
  output logic [4:0]      err_code,
  output logic [PA_W-1:0] pa,
  output logic            mem_req,
  output logic            mem_we,
  output logic [PA_W-1:0] mem_addr,
  output logic [E_W-1:0]  mem_wdata,
  input  logic            mem_ack,
  input  logic [E_W-1:0]  mem_rdata
);
  localparam int LVLS   = 4;
  localparam int LG_OFF = OFF_W + IDX_W;
  localparam int B_P = 0, B_W = 1, B_U = 2, B_A = 5, B_D = 6, B_PS = 7;

  typedef enum logic [2:0] {S_IDLE, S_RD4, S_RD3, S_RD2, S_RD1, S_CHK, S_WB, S_DONE} st_t;
  st_t st;

  logic [VA_W-1:0] va_q;
  logic            wr_q, us_q, fx_q, wp_q, nx_q;
  logic [PA_W-1:0] base_q;
  logic [E_W-1:0]  ent_q [LVLS];
  logic [PA_W-1:0] ea_q  [LVLS];
  logic [LVLS-1:0] rd_mask, wb_pend;
  logic            np_q, rsv_q, large_q;
  logic            fault_q;
  logic [4:0]      err_q;
  logic [PA_W-1:0] pa_q;

  logic [1:0]      lvl;
  logic            rd_st;
  logic [VA_W-1:0] sh_va;
  logic [PA_W-1:0] rd_addr;
  logic            e_np, e_rsv, e_lg;
  logic [E_W-1:0]  upd [LVLS];
  logic [LVLS-1:0] wb_c;
  logic            perm_flt, walk_flt;
  logic [4:0]      err_c;
  logic [PA_W-1:0] pa_c;
  logic [1:0]      wb_k;
  logic [LVLS-1:0] wb_left;

  always_comb begin
    rd_st = 1'b1;
    case (st)
      S_RD4:   lvl = 2'd3;
      S_RD3:   lvl = 2'd2;
      S_RD2:   lvl = 2'd1;
      S_RD1:   lvl = 2'd0;
      default: begin lvl = 2'd0; rd_st = 1'b0; end
    endcase
  end

  assign sh_va   = va_q >> (OFF_W + IDX_W * int'(lvl));
  assign rd_addr = base_q + PA_W'({sh_va[IDX_W-1:0], 3'b000});

  assign e_np  = !mem_rdata[B_P];
  assign e_rsv = mem_rdata[RSV_BIT] | (mem_rdata[NX_BIT] & !nx_q);
  assign e_lg  = (lvl == 2'd1) && mem_rdata[B_PS];

  always_comb begin
    perm_flt = 1'b0;
    for (int k = 0; k < LVLS; k++) begin
      upd[k] = ent_q[k];
      upd[k][B_A] = 1'b1;
      if (wr_q && (k == (large_q ? 1 : 0))) upd[k][B_D] = 1'b1;
      wb_c[k] = rd_mask[k] && (upd[k] != ent_q[k]);
      if (rd_mask[k]) begin
        if (us_q && !ent_q[k][B_U]) perm_flt = 1'b1;
        if (wr_q && !ent_q[k][B_W] && (wp_q || us_q)) perm_flt = 1'b1;
        if (fx_q && nx_q && ent_q[k][NX_BIT]) perm_flt = 1'b1;
      end
    end
  end

  assign walk_flt = np_q | rsv_q | perm_flt;
  assign err_c    = {fx_q & nx_q, rsv_q, us_q, wr_q, !np_q};
  assign pa_c     = large_q ? {ent_q[1][PA_W-1:LG_OFF+1], 1'b0, va_q[LG_OFF-1:0]}
                            : {ent_q[0][PA_W-1:OFF_W], va_q[OFF_W-1:0]};

  always_comb begin
    wb_k = 2'd0;
    for (int k = 0; k < LVLS; k++)
      if (wb_pend[k]) wb_k = 2'(k);
    wb_left = wb_pend;
    wb_left[wb_k] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      va_q <= '0; wr_q <= 1'b0; us_q <= 1'b0; fx_q <= 1'b0; wp_q <= 1'b0; nx_q <= 1'b0;
      base_q <= '0; rd_mask <= '0; wb_pend <= '0;
      np_q <= 1'b0; rsv_q <= 1'b0; large_q <= 1'b0;
      fault_q <= 1'b0; err_q <= '0; pa_q <= '0;
      for (int k = 0; k < LVLS; k++) begin
        ent_q[k] <= '0;
        ea_q[k]  <= '0;
      end
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          va_q <= req_va; wr_q <= req_write; us_q <= req_user; fx_q <= req_fetch;
          wp_q <= wp_en; nx_q <= nx_en;
          base_q <= {root_base[PA_W-1:OFF_W], {OFF_W{1'b0}}};
          rd_mask <= '0; np_q <= 1'b0; rsv_q <= 1'b0; large_q <= 1'b0;
          st <= S_RD4;
        end
        S_RD4, S_RD3, S_RD2, S_RD1: if (mem_ack) begin
          ent_q[lvl] <= mem_rdata;
          ea_q[lvl]  <= rd_addr;
          rd_mask[lvl] <= 1'b1;
          base_q <= {mem_rdata[PA_W-1:OFF_W], {OFF_W{1'b0}}};
          if (e_np) begin
            np_q <= 1'b1; st <= S_CHK;
          end else if (e_rsv) begin
            rsv_q <= 1'b1; st <= S_CHK;
          end else if (e_lg) begin
            large_q <= 1'b1; st <= S_CHK;
          end else begin
            case (st)
              S_RD4:   st <= S_RD3;
              S_RD3:   st <= S_RD2;
              S_RD2:   st <= S_RD1;
              default: st <= S_CHK;
            endcase
          end
        end
        S_CHK: begin
          fault_q <= walk_flt;
          err_q   <= err_c;
          pa_q    <= walk_flt ? '0 : pa_c;
          wb_pend <= walk_flt ? '0 : wb_c;
          st      <= (!walk_flt && |wb_c) ? S_WB : S_DONE;
        end
        S_WB: if (mem_ack) begin
          wb_pend <= wb_left;
          if (wb_left == '0) st <= S_DONE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy      = (st != S_IDLE);
  assign done      = (st == S_DONE);
  assign fault     = fault_q;
  assign err_code  = err_q;
  assign pa        = pa_q;
  assign mem_req   = rd_st || (st == S_WB);
  assign mem_we    = (st == S_WB);
  assign mem_addr  = (st == S_WB) ? ea_q[wb_k] : rd_addr;
  assign mem_wdata = (st == S_WB) ? upd[wb_k] : '0;

  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));
  // R1
  addr_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_addr[2:0] == 3'b000);
  // R8
  wb_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> !walk_flt);
  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !busy);
  // R5
  np_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && fault && !err_code[0] |-> !err_code[3]);
  // R8
  flt_pa_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && fault |-> pa == '0);
endmodule

// File: tb/test_pt_walker.sv
module test_pt_walker;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_user = 1'b0, req_fetch = 1'b0;
  logic wp_en = 1'b0, nx_en = 1'b0;
  logic [47:0] req_va = '0;
  logic [39:0] root_base = '0;
  logic busy, done, fault, mem_req, mem_we;
  logic [4:0] err_code;
  logic [39:0] pa, mem_addr;
  logic [63:0] mem_wdata;
  logic mem_ack = 1'b0;
  logic [63:0] mem_rdata = '0;

  always #4 clk = ~clk;

  pt_walker i_pt_walker (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_va(req_va),
    .req_write(req_write), .req_user(req_user), .req_fetch(req_fetch),
    .wp_en(wp_en), .nx_en(nx_en), .root_base(root_base),
    .busy(busy), .done(done), .fault(fault), .err_code(err_code), .pa(pa),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata));

  localparam logic [63:0] P = 64'h1, W = 64'h2, U = 64'h4, A = 64'h20, D = 64'h40, PS = 64'h80;
  localparam logic [63:0] RSV = 64'h1 << 51, NX = 64'h1 << 63;
  localparam logic [39:0] ROOT = 40'h00_0010_0000, T3 = 40'h00_0020_0000;
  localparam logic [39:0] T2 = 40'h00_0030_0000, T1 = 40'h00_0040_0000, PHYS = 40'h00_8765_4000;

  logic [63:0] mem [logic [39:0]];
  int n_rd = 0, n_wr = 0, lat = 0, dly = 0;
  logic [39:0] rd_log [16];
  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always @(posedge clk) begin
    if (mem_ack) mem_ack <= 1'b0;
    else if (mem_req) begin
      if (dly < lat) dly <= dly + 1;
      else begin
        dly <= 0;
        mem_ack <= 1'b1;
        if (mem_we) begin
          mem[mem_addr] = mem_wdata;
          n_wr <= n_wr + 1;
        end else begin
          mem_rdata <= mem.exists(mem_addr) ? mem[mem_addr] : 64'h0;
          rd_log[n_rd % 16] <= mem_addr;
          n_rd <= n_rd + 1;
        end
      end
    end
  end

  function automatic logic [39:0] eaddr(logic [39:0] base, logic [47:0] va, int l);
    logic [47:0] s = va >> (12 + 9 * (l - 1));
    return base + {28'h0, s[8:0], 3'b000};
  endfunction

  function automatic logic [63:0] rdm(logic [39:0] a);
    return mem.exists(a) ? mem[a] : 64'h0;
  endfunction

  task automatic check(string r, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", r, act, exp);
    end
  endtask

  task automatic build(logic [47:0] va, logic [63:0] f4, logic [63:0] f3, logic [63:0] f2,
                       logic [63:0] f1, logic [39:0] leaf);
    mem.delete();
    mem[eaddr(ROOT, va, 4)] = {24'h0, T3} | f4;
    mem[eaddr(T3, va, 3)]   = {24'h0, T2} | f3;
    mem[eaddr(T2, va, 2)]   = (f2 & PS) ? ({24'h0, leaf} | f2) : ({24'h0, T1} | f2);
    mem[eaddr(T1, va, 1)]   = {24'h0, leaf} | f1;
  endtask

  task automatic walk(logic [47:0] va, logic wr, logic us, logic fx, logic wp, logic nx);
    @(negedge clk);
    req_va = va; req_write = wr; req_user = us; req_fetch = fx; wp_en = wp; nx_en = nx;
    root_base = ROOT | 40'h123;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    while (!done) @(negedge clk);
  endtask

  task automatic t_reset;
    check("R10 busy", busy, 0);
    check("R10 done", done, 0);
    check("R10 mem_req", mem_req, 0);
  endtask

  task automatic t_read4k;
    logic [47:0] va = 48'h1234_5678_9ABC;
    int r0, w0;
    logic [39:0] a [4];
    build(va, P|W|U, P|W|U, P|W|U, P|W|U, PHYS);
    a[0] = eaddr(ROOT, va, 4); a[1] = eaddr(T3, va, 3);
    a[2] = eaddr(T2, va, 2);   a[3] = eaddr(T1, va, 1);
    r0 = n_rd; w0 = n_wr; lat = 2;
    walk(va, 0, 0, 0, 1, 1);
    check("R4 fault", fault, 0);
    check("R4 pa", pa, {PHYS[39:12], va[11:0]});
    check("R1 reads", n_rd - r0, 4);
    for (int i = 0; i < 4; i++) check("R1 R2 read addr", rd_log[(r0 + i) % 16], a[i]);
    check("R8 writes", n_wr - w0, 4);
    check("R8 leaf A no D", rdm(a[3]) & (A|D), A);
    check("R8 top A", rdm(a[0]) & A, A);
    lat = 0;
  endtask

  task automatic t_write_leaf;
    logic [47:0] va = 48'h0000_7FFF_F123;
    int w0;
    build(va, P|W|U|A, P|W|U|A, P|W|U|A, P|W|U, PHYS);
    w0 = n_wr;
    walk(va, 1, 0, 0, 1, 1);
    check("R8 fault", fault, 0);
    check("R8 one write", n_wr - w0, 1);
    check("R8 leaf A D", rdm(eaddr(T1, va, 1)) & (A|D), A|D);
    check("R4 pa", pa, {PHYS[39:12], va[11:0]});
  endtask

  task automatic t_large;
    logic [47:0] va = 48'h0000_4012_3456;
    logic [39:0] lb = 40'h00_4060_0000;
    int r0;
    build(va, P|W|U|A, P|W|U|A, P|W|U|PS, 64'h0, lb);
    r0 = n_rd;
    walk(va, 1, 0, 0, 1, 1);
    check("R3 fault", fault, 0);
    check("R3 reads", n_rd - r0, 3);
    check("R3 pa", pa, {lb[39:22], 1'b0, va[20:0]});
    check("R8 large A D", rdm(eaddr(T2, va, 2)) & (A|D), A|D);
  endtask

  task automatic t_not_present;
    logic [47:0] va = 48'h0ABC_DEF0_1000;
    int r0, w0;
    build(va, P|W|U, W|U, P|W|U, P|W|U, PHYS);
    r0 = n_rd; w0 = n_wr;
    walk(va, 0, 0, 0, 1, 1);
    check("R5 fault", fault, 1);
    check("R5 err", err_code, 5'h00);
    check("R5 reads", n_rd - r0, 2);
    check("R8 no writes", n_wr - w0, 0);
    check("R8 pa zero", pa, 0);
  endtask

  task automatic t_reserved;
    logic [47:0] va = 48'h0000_1111_2000;
    int r0, w0;
    build(va, P|W|U, P|W|U, P|W|U, P|W|U|RSV, PHYS);
    r0 = n_rd; w0 = n_wr;
    walk(va, 0, 1, 0, 1, 1);
    check("R6 fault", fault, 1);
    check("R6 err", err_code, 5'h0D);
    check("R6 writes", n_wr - w0, 0);
    build(va, P|W|U, P|W|U, P|W|U|NX, P|W|U, PHYS);
    r0 = n_rd;
    walk(va, 0, 0, 1, 1, 0);
    check("R6 nx-off fault", fault, 1);
    check("R6 R7 nx-off err", err_code, 5'h09);
    check("R6 nx-off reads", n_rd - r0, 3);
  endtask

  task automatic t_perm;
    logic [47:0] va = 48'h0000_2222_3000;
    build(va, P|W|U, P|W|U, P|W|U, P|W|U|NX, PHYS);
    walk(va, 0, 0, 1, 1, 1);
    check("R7 fetch nx fault", fault, 1);
    check("R7 fetch err", err_code, 5'h11);
    walk(va, 0, 0, 0, 1, 1);
    check("R7 read nx ok", fault, 0);
    build(va, P|W|U, P|W|U, P|W|U, P|U, PHYS);
    walk(va, 1, 0, 0, 0, 1);
    check("R7 wp off write ok", fault, 0);
    check("R8 wp off dirty", rdm(eaddr(T1, va, 1)) & D, D);
    build(va, P|W|U, P|W|U, P|W|U, P|U, PHYS);
    walk(va, 1, 0, 0, 1, 1);
    check("R7 wp on fault", fault, 1);
    check("R7 wp err", err_code, 5'h03);
    check("R8 no dirty", rdm(eaddr(T1, va, 1)) & (A|D), 0);
    build(va, P|W|U, P|W, P|W|U, P|W|U, PHYS);
    walk(va, 0, 1, 0, 1, 1);
    check("R7 user fault", fault, 1);
    check("R7 user err", err_code, 5'h05);
  endtask

  task automatic t_busy_ignore;
    logic [47:0] va = 48'h0000_3333_4000;
    int r0, dn = 0;
    build(va, P|W|U|A, P|W|U|A, P|W|U|A, P|W|U|A, PHYS);
    r0 = n_rd;
    @(negedge clk);
    req_va = va; req_write = 0; req_user = 0; req_fetch = 0; root_base = ROOT;
    req_valid = 1'b1;
    @(negedge clk);
    req_va = 48'h0000_9999_9000;
    repeat (3) @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < 40; i++) begin
      if (done) dn++;
      @(negedge clk);
    end
    check("R9 one done", dn, 1);
    check("R9 reads", n_rd - r0, 4);
    check("R9 pa first va", pa, {PHYS[39:12], va[11:0]});
    check("R9 idle", busy, 0);
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_read4k;
    t_write_leaf;
    t_large;
    t_not_present;
    t_reserved;
    t_perm;
    t_busy_ignore;
    finish_run;
  end

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run;
  end
endmodule